// File: doc/BRIEF.md
# Floating-Point Adder/Subtractor with Leading-One Normalisation

This block adds or subtracts two 18-bit floating-point numbers. Each word holds a sign in bit 17, a 7-bit biased exponent (bias 63) in bits 16:10 and a 10-bit fraction in bits 9:0, with a hidden leading one. The datapath runs as a fixed step sequence. It first compares and subtracts the exponents. It then right-aligns the smaller-exponent significand and keeps guard, round and sticky bits. Next it adds or subtracts according to the effective operation. A negative raw difference is turned back into sign-magnitude. A leading-one detector then measures how far the sum sits from the normal position. That distance moves the significand right or left and corrects the exponent. Finally the result is rounded to nearest-even, and a renormalising shift follows if the rounding carries out.

A caller presents one operation per cycle with `in_valid`. Each result comes out three clock cycles later, qualified by `out_valid`. Results keep the order of the inputs and there is no back-pressure. Two flags report an exponent that leaves the representable range. No infinities, NaNs or subnormal numbers are produced.

Top module: `fp18_addsub`

## Requirements
- R1: `out_valid` rises exactly three clock cycles after each cycle with `in_valid` high. Back-to-back inputs give back-to-back results in the same order. While reset is held, and until the first input, `out_valid`, `ovf` and `unf` are 0.
- R2: Word layout is sign bit 17, exponent bits 16:10 (bias 63), fraction bits 9:0. `op_sub`=1 requests opa−opb and `op_sub`=0 requests opa+opb. The magnitudes are added when the effective signs agree and subtracted when they differ.
- R3: The significand with the smaller exponent is shifted right by the exponent difference. Bits shifted out survive as guard, round and sticky information. A difference wider than the datapath leaves only a sticky contribution.
- R4: When the exponents are equal and opb's significand is larger, the negative raw difference is converted to a magnitude and the result sign is the inverse of opa's sign.
- R5: A carry out of the significand add shifts the result right by one and raises the exponent by one. Cancellation shifts it left until the hidden bit is set and lowers the exponent by the shift distance.
- R6: Rounding is to nearest with ties to even, using guard, round and sticky bits below the fraction LSB.
- R7: When rounding carries out of the significand, the result is shifted right once more and the exponent rises by one.
- R8: An exact zero result is encoded as 18'h00000, whatever the operand signs.
- R9: If the final biased exponent exceeds 127, `ovf` is 1 and the result is the largest magnitude (exponent 127, fraction 10'h3FF) carrying the result sign.
- R10: If the final biased exponent falls below 1, `unf` is 1 and the result is 18'h00000.
- R11: An operand whose exponent field is 0 counts as zero, whatever its fraction bits.
- R12: `ovf` and `unf` are never both 1, and neither is 1 without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_sub | input | 1 | 1 = subtract opb from opa, 0 = add |
| opa | input | 18 | First operand |
| opb | input | 18 | Second operand |
| out_valid | output | 1 | Result and flags valid this cycle |
| result | output | 18 | Sum or difference |
| ovf | output | 1 | Exponent overflow, result saturated |
| unf | output | 1 | Exponent underflow, result forced to zero |

## Verification
The bench targets the cases where the exponent swap leaves the wrong operand on top. Equal exponents with a larger subtrahend expose a missing magnitude conversion: the design would return a huge wrapped significand or the wrong sign. Ties and sticky-only contributions catch rounding that ignores even-ness or drops shifted-out bits, which shows up as a one-LSB error. An all-ones fraction plus half an LSB catches a design that forgets to renormalise after the rounding carry: it would emit fraction zero with an unchanged exponent, which halves the value. Deep cancellation near the smallest exponent, and sums at the largest exponent, check that the flags fire and the results are forced rather than wrapping into a small or large exponent.

// File: rtl/fpas_pkg.sv
package fpas_pkg;

  // Default word geometry: 1 sign, 7 exponent, 10 fraction bits
  localparam int unsigned FPAS_EXP_W  = 7;
  localparam int unsigned FPAS_FRAC_W = 10;

  // Number of extra alignment bits kept below the fraction LSB (guard, round, sticky)
  localparam int unsigned FPAS_XTRA_W = 3;

  // Direction of the normalising shift chosen from the leading-one position
  typedef enum logic [1:0] {
    NRM_HOLD  = 2'd0,
    NRM_RIGHT = 2'd1,
    NRM_LEFT  = 2'd2,
    NRM_ZERO  = 2'd3
  } nrm_dir_e;

endpackage

// File: rtl/fpas_align.sv
module fpas_align #(
  parameter int unsigned EXP_W  = fpas_pkg::FPAS_EXP_W,
  parameter int unsigned FRAC_W = fpas_pkg::FPAS_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0]                       a_word,
  input  logic [EXP_W+FRAC_W:0]                       b_word,
  input  logic                                        sub_req,
  output logic                                        big_sign,
  output logic                                        eff_sub,
  output logic [EXP_W-1:0]                            big_exp,
  output logic [FRAC_W+fpas_pkg::FPAS_XTRA_W:0]       big_sig,
  output logic [FRAC_W+fpas_pkg::FPAS_XTRA_W:0]       small_sig
);
  localparam int unsigned W     = 1 + EXP_W + FRAC_W;
  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned EXT_W = SIG_W + fpas_pkg::FPAS_XTRA_W;

  logic              a_sign, b_sign;
  logic [EXP_W-1:0]  a_exp, b_exp, small_exp, exp_gap;
  logic [SIG_W-1:0]  a_sig, b_sig, big_raw, small_raw;
  logic              small_sign, take_b;
  logic [EXT_W-1:0]  small_ext, lost_mask, shifted;
  logic              sticky;

  // Unpack; a zero exponent field means a zero operand (hidden bit clear, fraction ignored)
  always_comb begin
    a_sign = a_word[W-1];
    b_sign = b_word[W-1] ^ sub_req;
    a_exp  = a_word[W-2 -: EXP_W];
    b_exp  = b_word[W-2 -: EXP_W];
    a_sig  = (a_exp != '0) ? {1'b1, a_word[FRAC_W-1:0]} : '0;
    b_sig  = (b_exp != '0) ? {1'b1, b_word[FRAC_W-1:0]} : '0;
  end

  // Exponent comparison decides which operand is aligned
  always_comb begin
    take_b     = (b_exp > a_exp);
    big_exp    = take_b ? b_exp  : a_exp;
    small_exp  = take_b ? a_exp  : b_exp;
    big_raw    = take_b ? b_sig  : a_sig;
    small_raw  = take_b ? a_sig  : b_sig;
    big_sign   = take_b ? b_sign : a_sign;
    small_sign = take_b ? a_sign : b_sign;
    eff_sub    = big_sign ^ small_sign;
    exp_gap    = big_exp - small_exp;
  end

  // Mask of the bit positions that fall off the right end
  for (genvar i = 0; i < EXT_W; i++) begin : g_mask
    assign lost_mask[i] = (i < int'(exp_gap));
  end

  // Right alignment with the sticky OR folded into the lowest bit
  always_comb begin
    small_ext = {small_raw, {fpas_pkg::FPAS_XTRA_W{1'b0}}};
    shifted   = (int'(exp_gap) >= EXT_W) ? '0 : (small_ext >> exp_gap);
    sticky    = |(small_ext & lost_mask);
    small_sig = {shifted[EXT_W-1:1], shifted[0] | sticky};
    big_sig   = {big_raw, {fpas_pkg::FPAS_XTRA_W{1'b0}}};
  end

endmodule

// File: rtl/fpas_lead1.sv
module fpas_lead1 #(
  parameter int unsigned N  = 15,
  parameter int unsigned PW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [PW-1:0] pos
);
  // Highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/fpas_normrnd.sv
module fpas_normrnd #(
  parameter int unsigned EXP_W  = fpas_pkg::FPAS_EXP_W,
  parameter int unsigned FRAC_W = fpas_pkg::FPAS_FRAC_W,
  parameter int unsigned SH_W   = 6
) (
  input  logic                                   sign_in,
  input  logic [EXP_W-1:0]                       exp_in,
  input  logic [FRAC_W+fpas_pkg::FPAS_XTRA_W+1:0] mag_in,
  input  logic                                   is_zero,
  input  logic signed [SH_W-1:0]                 shift_en,
  output logic [EXP_W+FRAC_W:0]                  word_out,
  output logic                                   ovf_out,
  output logic                                   unf_out
);
  import fpas_pkg::*;

  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned EXT_W = SIG_W + FPAS_XTRA_W;
  localparam int unsigned EW2   = EXP_W + 3;
  localparam int unsigned EMAX  = (1 << EXP_W) - 1;

  nrm_dir_e            dir;
  logic [SH_W-1:0]     lsh;
  logic [EXT_W-1:0]    norm;
  logic [SIG_W-1:0]    keep;
  logic                g_bit, r_bit, s_bit, bump;
  logic [SIG_W:0]      rsum;
  logic                rcarry;
  logic [FRAC_W-1:0]   frac;
  logic signed [EW2-1:0] exp_fin;

  // Pick the shift direction from the signed distance En
  always_comb begin
    if (is_zero)            dir = NRM_ZERO;
    else if (shift_en > 0)  dir = NRM_RIGHT;
    else if (shift_en < 0)  dir = NRM_LEFT;
    else                    dir = NRM_HOLD;
  end

  // Normalise
  always_comb begin
    lsh = -shift_en;
    case (dir)
      NRM_RIGHT: norm = {mag_in[EXT_W:2], mag_in[1] | mag_in[0]};
      NRM_LEFT:  norm = mag_in[EXT_W-1:0] << lsh;
      default:   norm = mag_in[EXT_W-1:0];
    endcase
  end

  // Round to nearest, ties to even, then renormalise on carry
  always_comb begin
    keep   = norm[EXT_W-1:FPAS_XTRA_W];
    g_bit  = norm[2];
    r_bit  = norm[1];
    s_bit  = norm[0];
    bump   = g_bit & (r_bit | s_bit | keep[0]);
    rsum   = {1'b0, keep} + {{SIG_W{1'b0}}, bump};
    rcarry = rsum[SIG_W];
    frac   = rcarry ? rsum[SIG_W-1:1] : rsum[FRAC_W-1:0];
    exp_fin = $signed({3'b000, exp_in}) + EW2'(shift_en) + $signed({{(EW2-1){1'b0}}, rcarry});
  end

  // Range checks and final packing
  always_comb begin
    ovf_out  = !is_zero && (exp_fin > $signed(EW2'(EMAX)));
    unf_out  = !is_zero && (exp_fin < $signed(EW2'(1)));
    if (is_zero || unf_out)
      word_out = '0;
    else if (ovf_out)
      word_out = {sign_in, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
    else
      word_out = {sign_in, exp_fin[EXP_W-1:0], frac};
  end

endmodule

// File: rtl/fp18_addsub.sv
module fp18_addsub #(
  parameter int unsigned EXP_W  = fpas_pkg::FPAS_EXP_W,
  parameter int unsigned FRAC_W = fpas_pkg::FPAS_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    op_sub,
  input  logic [EXP_W+FRAC_W:0]   opa,
  input  logic [EXP_W+FRAC_W:0]   opb,
  output logic                    out_valid,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    ovf,
  output logic                    unf
);
  localparam int unsigned W     = 1 + EXP_W + FRAC_W;
  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned EXT_W = SIG_W + fpas_pkg::FPAS_XTRA_W;
  localparam int unsigned SUM_W = EXT_W + 1;
  localparam int unsigned PW    = $clog2(SUM_W);
  localparam int unsigned SH_W  = PW + 2;

  // ---------------- reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // ---------------- stage 1: exponent difference, swap, alignment
  logic             al_sign, al_sub;
  logic [EXP_W-1:0] al_exp;
  logic [EXT_W-1:0] al_big, al_small;

  fpas_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .a_word    (opa),
    .b_word    (opb),
    .sub_req   (op_sub),
    .big_sign  (al_sign),
    .eff_sub   (al_sub),
    .big_exp   (al_exp),
    .big_sig   (al_big),
    .small_sig (al_small)
  );

  logic             s1_valid, s1_sign, s1_sub;
  logic [EXP_W-1:0] s1_exp;
  logic [EXT_W-1:0] s1_big, s1_small;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_sub   <= 1'b0;
      s1_exp   <= '0;
      s1_big   <= '0;
      s1_small <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign  <= al_sign;
        s1_sub   <= al_sub;
        s1_exp   <= al_exp;
        s1_big   <= al_big;
        s1_small <= al_small;
      end
    end
  end

  // ---------------- stage 2: add/subtract, sign-magnitude conversion, leading one
  logic [SUM_W:0]          raw;
  logic                    raw_neg, sum_sign;
  logic [SUM_W-1:0]        mag;
  logic                    lead_found;
  logic [PW-1:0]           lead_pos;
  logic signed [SH_W-1:0]  en_c;

  always_comb begin
    if (s1_sub) raw = {2'b00, s1_big} - {2'b00, s1_small};
    else        raw = {2'b00, s1_big} + {2'b00, s1_small};
    raw_neg  = s1_sub & raw[SUM_W];
    mag      = raw_neg ? SUM_W'(~raw + 1'b1) : raw[SUM_W-1:0];
    sum_sign = s1_sign ^ raw_neg;
  end

  fpas_lead1 #(.N(SUM_W), .PW(PW)) u_lead1 (
    .vec   (mag),
    .found (lead_found),
    .pos   (lead_pos)
  );

  // Distance from the normal hidden-bit position; positive means shift right
  assign en_c = SH_W'(lead_pos) - SH_W'(EXT_W - 1);

  logic                   s2_valid, s2_sign, s2_zero;
  logic [EXP_W-1:0]       s2_exp;
  logic [SUM_W-1:0]       s2_mag;
  logic signed [SH_W-1:0] s2_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s2_valid <= 1'b0;
      s2_sign  <= 1'b0;
      s2_zero  <= 1'b1;
      s2_exp   <= '0;
      s2_mag   <= '0;
      s2_en    <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_sign <= sum_sign;
        s2_zero <= !lead_found;
        s2_exp  <= s1_exp;
        s2_mag  <= mag;
        s2_en   <= en_c;
      end
    end
  end

  // ---------------- stage 3: normalise, round, range check
  logic [W-1:0] nr_word;
  logic         nr_ovf, nr_unf;

  fpas_normrnd #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_normrnd (
    .sign_in  (s2_sign),
    .exp_in   (s2_exp),
    .mag_in   (s2_mag),
    .is_zero  (s2_zero),
    .shift_en (s2_en),
    .word_out (nr_word),
    .ovf_out  (nr_ovf),
    .unf_out  (nr_unf)
  );

  logic         vld_d, ovf_d, unf_d;
  logic [W-1:0] res_d;

  always_comb begin
    vld_d = s2_valid;
    ovf_d = s2_valid & nr_ovf;
    unf_d = s2_valid & nr_unf;
    res_d = s2_valid ? nr_word : result;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= vld_d;
      ovf       <= ovf_d;
      unf       <= unf_d;
      result    <= res_d;
    end
  end

endmodule

// File: rtl/fp18_addsub_chk.sv
module fp18_addsub_chk #(
  parameter int unsigned EXP_W  = 7,
  parameter int unsigned FRAC_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W-1:0]      a_exp,
  input logic [EXP_W-1:0]      b_exp,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  ovf,
  input logic                  unf
);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));

  assert_zero_encoding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[EXP_W+FRAC_W-1 -: EXP_W] == '0) |-> result == '0);

  assert_ovf_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> result[EXP_W+FRAC_W-1:0] == '1);

  assert_unf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> result == '0);

  assert_zero_operands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && a_exp == '0 && b_exp == '0, 3)) |-> (result == '0 && !ovf && !unf));

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  assert_flags_qualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |-> out_valid);

endmodule

bind fp18_addsub fp18_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a_exp     (opa[EXP_W+FRAC_W-1 -: EXP_W]),
  .b_exp     (opb[EXP_W+FRAC_W-1 -: EXP_W]),
  .out_valid (out_valid),
  .result    (result),
  .ovf       (ovf),
  .unf       (unf)
);

// File: tb/sim_fp18_addsub.sv
`timescale 1ns/1ps
module sim_fp18_addsub;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        op_sub;
  logic [17:0] opa, opb;
  logic        out_valid;
  logic [17:0] result;
  logic        ovf, unf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fp18_addsub u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
    .ovf(ovf), .unf(unf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [17:0] mk(input logic s, input int e, input int f);
    return {s, 7'(e), 10'(f)};
  endfunction

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual vld=%0b ovf=%0b unf=%0b res=%05h expected vld=%0b ovf=%0b unf=%0b res=%05h",
               tag, act[20], act[19], act[18], act[17:0], exp_v[20], exp_v[19], exp_v[18], exp_v[17:0]);
    end
  endtask

  task automatic do_op(input logic [17:0] a, input logic [17:0] b, input logic sub,
                       input logic [17:0] er, input logic eo, input logic eu, input string tag);
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; op_sub = sub;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(tag, {out_valid, ovf, unf, result}, {1'b1, eo, eu, er});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; opa = '0; opb = '0;
    repeat (5) @(negedge clk);
    check("R1 reset state", {out_valid, ovf, unf, 18'h0}, 21'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {out_valid, ovf, unf, 18'h0}, 21'h0);
  endtask

  task automatic t_basic();
    do_op(mk(0,63,0),     mk(0,63,0),     1'b0, mk(0,64,0),     0, 0, "R5 1+1 right shift");
    do_op(mk(0,63,10'h200), mk(0,63,10'h200), 1'b0, mk(0,64,10'h200), 0, 0, "R5 1.5+1.5");
    do_op(mk(0,63,0),     mk(0,64,0),     1'b0, mk(0,64,10'h200), 0, 0, "R3 1+2 swap");
  endtask

  task automatic t_signs();
    do_op(mk(0,63,0), mk(1,63,0), 1'b1, mk(0,64,0), 0, 0, "R2 1-(-1)");
    do_op(mk(1,63,0), mk(1,63,0), 1'b0, mk(1,64,0), 0, 0, "R2 -1+-1");
    do_op(mk(0,64,0), mk(0,63,0), 1'b1, mk(0,63,0), 0, 0, "R2 2-1");
  endtask

  task automatic t_convert();
    do_op(mk(0,63,0), mk(0,63,10'h200), 1'b1, mk(1,62,0), 0, 0, "R4 1-1.5");
    do_op(mk(0,63,0), mk(1,63,10'h200), 1'b0, mk(1,62,0), 0, 0, "R4 1+(-1.5)");
    do_op(mk(1,63,0), mk(1,63,10'h200), 1'b1, mk(0,62,0), 0, 0, "R4 -1-(-1.5)");
  endtask

  task automatic t_cancel();
    do_op(mk(0,64,0), mk(0,63,1), 1'b1, mk(0,62,10'h3FE), 0, 0, "R5 left shift by 2");
    do_op(mk(0,63,0), mk(0,52,0), 1'b1, mk(0,62,10'h3FF), 0, 0, "R5 1-2^-11");
  endtask

  task automatic t_round();
    do_op(mk(0,63,0), mk(0,52,0),       1'b0, mk(0,63,0), 0, 0, "R6 tie to even down");
    do_op(mk(0,63,1), mk(0,52,0),       1'b0, mk(0,63,2), 0, 0, "R6 tie to even up");
    do_op(mk(0,63,0), mk(0,52,10'h200), 1'b0, mk(0,63,1), 0, 0, "R6 above half");
    do_op(mk(0,63,0), mk(0,52,1),       1'b0, mk(0,63,1), 0, 0, "R3 sticky breaks tie");
    do_op(mk(0,63,0), mk(0,43,0),       1'b0, mk(0,63,0), 0, 0, "R3 far operand sticky only");
  endtask

  task automatic t_round_carry();
    do_op(mk(0,63,10'h3FF), mk(0,52,0), 1'b0, mk(0,64,0), 0, 0, "R7 rounding carry renormalises");
  endtask

  task automatic t_overflow();
    do_op(mk(0,127,10'h3FF), mk(0,127,10'h3FF), 1'b0, mk(0,127,10'h3FF), 1, 0, "R9 max+max");
    do_op(mk(1,127,0), mk(0,127,0), 1'b1, mk(1,127,10'h3FF), 1, 0, "R9 negative overflow");
    do_op(mk(0,127,10'h3FF), mk(0,116,0), 1'b0, mk(0,127,10'h3FF), 1, 0, "R7 R9 carry overflow");
  endtask

  task automatic t_underflow();
    do_op(mk(0,1,1), mk(0,1,0), 1'b1, 18'h0,     0, 1, "R10 deep cancellation");
    do_op(mk(0,2,0), mk(0,1,0), 1'b1, mk(0,1,0), 0, 0, "R10 smallest exponent kept");
  endtask

  task automatic t_zero();
    do_op(mk(0,63,0),       mk(0,63,0),       1'b1, 18'h0, 0, 0, "R8 1-1");
    do_op(mk(1,63,10'h200), mk(0,63,10'h200), 1'b0, 18'h0, 0, 0, "R8 -1.5+1.5");
    do_op(mk(0,0,10'h155),  mk(0,63,10'h200), 1'b0, mk(0,63,10'h200), 0, 0, "R11 zero opa");
    do_op(mk(0,63,10'h200), mk(1,0,10'h3FF),  1'b0, mk(0,63,10'h200), 0, 0, "R11 zero opb");
    do_op(mk(0,0,5),        mk(1,0,7),        1'b0, 18'h0, 0, 0, "R11 R12 both zero");
  endtask

  task automatic t_stream();
    logic [17:0] sa [4];
    logic [17:0] sb [4];
    logic        ss [4];
    logic [17:0] se [4];
    sa[0] = mk(0,63,0);       sb[0] = mk(0,63,0);       ss[0] = 0; se[0] = mk(0,64,0);
    sa[1] = mk(0,63,10'h200); sb[1] = mk(0,63,10'h200); ss[1] = 0; se[1] = mk(0,64,10'h200);
    sa[2] = mk(0,64,0);       sb[2] = mk(0,63,0);       ss[2] = 1; se[2] = mk(0,63,0);
    sa[3] = mk(0,63,0);       sb[3] = mk(0,63,10'h200); ss[3] = 1; se[3] = mk(1,62,0);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (t == 2) check("R1 no early result", {out_valid, 20'h0}, 21'h0);
      if (t >= 3 && t <= 6) check("R1 stream order", {out_valid, ovf, unf, result}, {1'b1, 1'b0, 1'b0, se[t-3]});
      if (t == 7) check("R1 stream drained", {out_valid, 20'h0}, 21'h0);
      if (t < 4) begin
        in_valid = 1'b1; opa = sa[t]; opb = sb[t]; op_sub = ss[t];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_signs();
    t_convert();
    t_cancel();
    t_round();
    t_round_carry();
    t_overflow();
    t_underflow();
    t_zero();
    t_stream();
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule